// File: doc/BRIEF.md
# DDR2 Write Strobe and Data Slice Generator

This block sits in the half-rate clock domain of a DDR2 write path. It feeds four output serializers' worth of parallel data: one nibble of DQ beats per data bit, one DQ tristate nibble, one DQS data nibble and one DQS tristate nibble per half-rate cycle. Each nibble holds four DDR beat slots. Bit i, or DQ field i, carries slot i, and slot 0 leaves the pin first. The controller marks a burst with two level inputs. The burst enable is high for two half-rate cycles for a 4-beat burst and three for an 8-beat burst. The burst stop input rises with the enable and is high for one cycle less. The final slice of the burst is the cycle where the enable is still high and the stop input has fallen.

Write data comes from a first-word-fall-through FIFO. Each entry carries four DQ beats, which is two fast-clock words, with beat k in field k. The entry at the FIFO head is consumed when the read strobe is high at a clock edge. Write latency is CAS latency minus one. An odd CAS latency is handled by moving every slice two slots (one fast cycle) later inside the serializer words, not by adding a whole half-rate cycle of delay. DQ slices are meant for a serializer clocked a quarter period after the strobe's, so the strobe lands centred on the data.

Top module: `ddr2_wr_slicer`

## Requirements
- R1: After a synchronous active-high reset, and whenever no burst is in flight, every tristate nibble is 4'hF and the DQ and DQS data outputs are all zero.
- R2: The FIFO read strobe is high in exactly those cycles where both the burst enable and the burst stop inputs are high. A 4-beat burst therefore reads one entry and an 8-beat burst reads two.
- R3: With odd latency low, the first slice of a burst appears two cycles after the first enable cycle. Slots 2 and 3 of that slice carry beats 0 and 1 of the first entry. In the final slice, slots 0 and 1 carry beats 2 and 3 of the last entry read. Slots with no beat are zero.
- R4: In the middle slice of an 8-beat burst, slots 0 and 1 carry beats 2 and 3 of the first entry, and slots 2 and 3 carry beats 0 and 1 of the second entry.
- R5: The DQ tristate nibble is 4'b0011 in the first slice, 4'b0000 in a middle slice and 4'b1100 in the final slice.
- R6: The DQS data nibble is 4'b1010 inside a burst. The first slice uses 4'b1000, holding a low preamble in slots 0 and 1. The final slice uses 4'b0010. The DQS tristate nibble is 4'b0000 in the first and middle slices and 4'b1100 in the final slice.
- R7: When a new burst's first slice directly follows a final slice, the final slice keeps DQS tristate at 4'b0000 and DQS data at 4'b1010, and the new first slice uses DQS data 4'b1010, so the strobe is driven and toggles with no gap.
- R8: With odd latency high, each output nibble and DQ word takes slots 2 and 3 of the previous even-latency slice into slots 0 and 1, and slots 0 and 1 of the current even-latency slice into slots 2 and 3.
- R9: In every slot, DQ driven implies DQS driven. A tristated slot carries zero on its DQ or DQS data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Burst enable from the controller |
| wr_stop_i | input | 1 | Burst stop input; its fall marks the final slice |
| odd_lat_i | input | 1 | High for odd CAS latency; static while bursts run |
| fifo_dat_i | input | 4*DQ_W | FIFO head entry, beat k in field k |
| fifo_rd_o | output | 1 | FIFO read strobe, one per entry consumed |
| dq_o | output | 4*DQ_W | DQ slots for the data serializers, slot i in field i |
| dq_tri_o | output | 4 | DQ tristate per slot, 1 means high impedance |
| dqs_o | output | 4 | DQS data per slot |
| dqs_tri_o | output | 4 | DQS tristate per slot, 1 means high impedance |

## Verification
The assertions check, on every cycle, the slot-level rules that do not depend on burst history. A driven DQ slot always has a driven DQS slot. Tristated slots carry zero. A strobe release always follows two cycles after a fresh burst begins. Only the bench's scenarios can show that FIFO beats reach the correct slots, because that depends on the order of entries. The same holds for the exact nibble sequences for 4-beat and 8-beat bursts, the gap-free strobe across back-to-back bursts, and the half-slice shift of the odd-latency mode. The bench checks these against a slot-level model of each burst.

// File: rtl/ddr2_wr_slicer.sv
module ddr2_wr_slicer #(
  parameter int DQ_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_stop_i,
  input  logic              odd_lat_i,
  input  logic [4*DQ_W-1:0] fifo_dat_i,
  output logic              fifo_rd_o,
  output logic [4*DQ_W-1:0] dq_o,
  output logic [3:0]        dq_tri_o,
  output logic [3:0]        dqs_o,
  output logic [3:0]        dqs_tri_o
);
  localparam int HW = 2 * DQ_W;
  localparam int SW = 4 * DQ_W;

  logic en_q, last_q;
  logic [HW-1:0] hold;
  logic first, last, lo_on, hi_on;

  logic [SW-1:0] s_dq;
  logic [3:0]    s_dqt, s_dqsd, s_dqst;

  logic [SW-1:0] e1_dq, e2_dq, e3_dq;
  logic [3:0]    e1_dqt, e2_dqt, e3_dqt;
  logic [3:0]    e1_dqsd, e2_dqsd, e3_dqsd;
  logic [3:0]    e1_dqst, e2_dqst, e3_dqst;
  logic          join_b;

  assign first  = wr_en_i & (~en_q | last_q);
  assign last   = wr_en_i & ~wr_stop_i;
  assign lo_on  = wr_en_i & ~first;
  assign hi_on  = wr_en_i & ~last;
  assign join_b = first & last_q;

  assign fifo_rd_o = wr_en_i & wr_stop_i;

  assign s_dq  = {hi_on ? fifo_dat_i[HW-1:0] : {HW{1'b0}},
                  lo_on ? hold : {HW{1'b0}}};
  assign s_dqt = {{2{~hi_on}}, {2{~lo_on}}};
  assign s_dqst = !wr_en_i ? 4'b1111 : (last ? 4'b1100 : 4'b0000);
  assign s_dqsd = !wr_en_i ? 4'b0000 :
                  first    ? (last_q ? 4'b1010 : 4'b1000) :
                  last     ? 4'b0010 : 4'b1010;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      last_q  <= 1'b0;
      hold    <= '0;
      e1_dq   <= '0;  e2_dq   <= '0;  e3_dq   <= '0;
      e1_dqt  <= '1;  e2_dqt  <= '1;  e3_dqt  <= '1;
      e1_dqsd <= '0;  e2_dqsd <= '0;  e3_dqsd <= '0;
      e1_dqst <= '1;  e2_dqst <= '1;  e3_dqst <= '1;
    end else begin
      en_q   <= wr_en_i;
      last_q <= last;
      if (fifo_rd_o) hold <= fifo_dat_i[SW-1:HW];
      e1_dq   <= s_dq;
      e1_dqt  <= s_dqt;
      e1_dqsd <= s_dqsd;
      e1_dqst <= s_dqst;
      e2_dq   <= e1_dq;
      e2_dqt  <= e1_dqt;
      e2_dqsd <= join_b ? 4'b1010 : e1_dqsd;
      e2_dqst <= join_b ? 4'b0000 : e1_dqst;
      e3_dq   <= e2_dq;
      e3_dqt  <= e2_dqt;
      e3_dqsd <= e2_dqsd;
      e3_dqst <= e2_dqst;
    end
  end

  assign dq_o      = odd_lat_i ? {e2_dq[HW-1:0], e3_dq[SW-1:HW]} : e2_dq;
  assign dq_tri_o  = odd_lat_i ? {e2_dqt[1:0], e3_dqt[3:2]}   : e2_dqt;
  assign dqs_o     = odd_lat_i ? {e2_dqsd[1:0], e3_dqsd[3:2]} : e2_dqsd;
  assign dqs_tri_o = odd_lat_i ? {e2_dqst[1:0], e3_dqst[3:2]} : e2_dqst;

  // R9
  strobe_covers_data_chk: assert property (@(posedge clk) disable iff (rst)
    ((~dq_tri_o & dqs_tri_o) == 4'b0000));

  // R9
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((dqs_o & dqs_tri_o) == 4'b0000));

  // R6
  preamble_start_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !$past(wr_en_i)) |=> ##1 (dqs_tri_o != 4'b1111));

  generate
    for (genvar i = 0; i < 4; i++) begin : g_slot
      // R9
      dq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        dq_tri_o[i] |-> (dq_o[i*DQ_W +: DQ_W] == '0));
    end
  endgenerate
endmodule

// File: tb/tb_ddr2_wr_slicer.sv
module tb_ddr2_wr_slicer;
  localparam int W = 8;
  localparam int N = 320;
  localparam int IDLE = 0, FIRST = 1, MID = 2, LAST = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en_i = 1'b0, wr_stop_i = 1'b0, odd_lat_i = 1'b0;
  logic [4*W-1:0] fifo_dat_i = '0;
  logic fifo_rd_o;
  logic [4*W-1:0] dq_o;
  logic [3:0] dq_tri_o, dqs_o, dqs_tri_o;

  int checks = 0, errors = 0;
  bit done = 0;

  int role [0:N-1];
  logic en_a [0:N-1];
  logic dis_a [0:N-1];
  logic [31:0] mem [0:511];
  logic [31:0] x_dq [0:N-1];
  logic [3:0] x_dqt [0:N-1], x_dqsd [0:N-1], x_dqst [0:N-1];
  bit patched [0:N-1];
  int entries;

  always #2 clk = ~clk;

  ddr2_wr_slicer #(.DQ_W(W)) dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_stop_i(wr_stop_i),
    .odd_lat_i(odd_lat_i), .fifo_dat_i(fifo_dat_i), .fifo_rd_o(fifo_rd_o),
    .dq_o(dq_o), .dq_tri_o(dq_tri_o), .dqs_o(dqs_o), .dqs_tri_o(dqs_tri_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic build(input int seed_mix);
    int cyc, ent, idx;
    for (int c = 0; c < N; c++) begin
      role[c] = IDLE; en_a[c] = 0; dis_a[c] = 0;
      x_dq[c] = '0; x_dqt[c] = 4'hF; x_dqsd[c] = 4'h0; x_dqst[c] = 4'hF;
      patched[c] = 0;
    end
    for (int e = 0; e < 512; e++) mem[e] = $urandom ^ seed_mix;
    cyc = 4; ent = 0; idx = 0;
    while (cyc < N - 12) begin
      int bl8, len, gap;
      bl8 = (idx == 1) ? 1 : (idx < 3 ? 0 : int'($urandom % 2));
      gap = (idx == 0) ? 2 : (idx < 3 ? 0 : int'($urandom % 3));
      len = bl8 ? 3 : 2;
      for (int k = 0; k < len; k++) begin
        int c;
        c = cyc + k;
        en_a[c] = 1;
        dis_a[c] = (k < len - 1);
        role[c] = (k == 0) ? FIRST : (k == len - 1 ? LAST : MID);
        if (role[c] == FIRST) begin
          x_dq[c] = {mem[ent][15:0], 16'h0};
          x_dqt[c] = 4'b0011; x_dqsd[c] = 4'b1000; x_dqst[c] = 4'b0000;
        end else if (role[c] == MID) begin
          x_dq[c] = {mem[ent+1][15:0], mem[ent][31:16]};
          x_dqt[c] = 4'b0000; x_dqsd[c] = 4'b1010; x_dqst[c] = 4'b0000;
        end else begin
          x_dq[c] = {16'h0, mem[ent+bl8][31:16]};
          x_dqt[c] = 4'b1100; x_dqsd[c] = 4'b0010; x_dqst[c] = 4'b1100;
        end
      end
      ent += 1 + bl8;
      cyc += len + gap;
      idx++;
    end
    entries = ent;
    for (int c = 1; c < N - 1; c++) begin
      if (role[c] == LAST && role[c+1] == FIRST) begin
        x_dqst[c] = 4'b0000; x_dqsd[c] = 4'b1010; patched[c] = 1;
      end
      if (role[c] == FIRST && role[c-1] == LAST) begin
        x_dqsd[c] = 4'b1010; patched[c] = 1;
      end
    end
  endtask

  function automatic logic [3:0] pick4(input logic [3:0] cur, input logic [3:0] prv, input bit odd);
    return odd ? {cur[1:0], prv[3:2]} : cur;
  endfunction

  task automatic run(input bit odd);
    int rdptr, reads;
    odd_lat_i = odd;
    rst = 1'b1;
    wr_en_i = 0; wr_stop_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset dq_tri", {28'h0, dq_tri_o}, 32'hF);
    chk("R1 reset dqs_tri", {28'h0, dqs_tri_o}, 32'hF);
    chk("R1 reset dq", dq_o, 32'h0);
    chk("R1 reset dqs", {28'h0, dqs_o}, 32'h0);
    rdptr = 0; reads = 0;
    for (int c = 0; c < N; c++) begin
      if (c > 0 && en_a[c-1] && dis_a[c-1]) rdptr++;
      if (c >= 2) begin
        int s;
        logic [31:0] edq, pdq;
        logic [3:0] pdqt, pdqsd, pdqst;
        string tg;
        s = c - 2;
        pdq   = (s > 0) ? x_dq[s-1]   : 32'h0;
        pdqt  = (s > 0) ? x_dqt[s-1]  : 4'hF;
        pdqsd = (s > 0) ? x_dqsd[s-1] : 4'h0;
        pdqst = (s > 0) ? x_dqst[s-1] : 4'hF;
        edq = odd ? {x_dq[s][15:0], pdq[31:16]} : x_dq[s];
        if (odd) tg = "R8";
        else if (role[s] == IDLE) tg = "R1";
        else if (role[s] == MID) tg = "R4";
        else tg = "R3";
        chk({tg, " dq slots"}, dq_o, edq);
        chk(odd ? "R8 dq_tri" : (role[s] == IDLE ? "R1 dq_tri" : "R5 dq_tri"),
            {28'h0, dq_tri_o}, {28'h0, pick4(x_dqt[s], pdqt, odd)});
        tg = odd ? "R8" : (patched[s] ? "R7" : (role[s] == IDLE ? "R1" : "R6"));
        chk({tg, " dqs"}, {28'h0, dqs_o}, {28'h0, pick4(x_dqsd[s], pdqsd, odd)});
        chk({tg, " dqs_tri"}, {28'h0, dqs_tri_o}, {28'h0, pick4(x_dqst[s], pdqst, odd)});
      end
      wr_en_i = en_a[c];
      wr_stop_i = dis_a[c];
      fifo_dat_i = mem[rdptr];
      #1;
      chk("R2 fifo read strobe", {31'h0, fifo_rd_o}, {31'h0, en_a[c] & dis_a[c]});
      if (fifo_rd_o) reads++;
      @(posedge clk);
    end
    chk("R2 entries read", reads, entries);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    build(32'h0);
    run(1'b0);
    build(32'h5A5A_A5A5);
    run(1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule